// File: doc/BRIEF.md
# MESI Snooping Cache Line Controller

This block keeps a small direct-mapped, write-back private cache coherent with its peers on an atomic snooping bus. Each line carries one of four coherence states: Modified (only copy, dirty), Exclusive (only copy, clean), Shared (clean, possibly held elsewhere) and Invalid. The processor side presents one read or write at a time and holds it until the block signals completion. Processor requests that need the bus are raised as a bus request, and the bus transaction completes in the cycle the grant arrives.

The bus side watches the traffic of other caches. For a snooped read to a line it holds, the block drives its shared output. For a snooped read or read-for-ownership that hits a Modified line, it flushes the dirty word in the same cycle. The line's state moves at the end of that cycle. A read miss samples the wired-OR shared input during its grant cycle. The line is filled as Exclusive when no other cache answers, so a later write to it upgrades to Modified without any bus traffic. A miss whose victim is Modified first writes the victim back to memory.

Top module: `mesi_line_ctl`

## Requirements
- R1: After reset every line is Invalid: a snooped read gets neither shared nor flush, and the first processor access to any address issues a bus request.
- R2: A read miss issues a bus read (command code 0). The line fills as Shared when bus_shared_in is high in the grant cycle, and as Exclusive otherwise. The two cases can be told apart because a later write to a Shared line issues a read-for-ownership and a write to an Exclusive line issues nothing.
- R3: A write to an Exclusive line completes in the cycle it is presented, issues no bus request, and leaves the line Modified, so a later snooped read flushes the new word.
- R4: A write miss, or a write to a Shared line, issues a read-for-ownership (command code 1) and leaves the line Modified holding the processor's word. On an upgrade from Shared, the bus_rdata value is ignored.
- R5: A read hit in any valid state, and a write hit in Modified, complete in the same cycle with no bus request.
- R6: A snooped read (snp_rdx = 0) that hits a Modified line raises snp_flush and snp_shared, drives the line's word on snp_data, and leaves the line Shared.
- R7: A snooped read that hits an Exclusive or Shared line raises snp_shared without a flush and leaves the line Shared.
- R8: A snooped read-for-ownership (snp_rdx = 1) that hits a valid line invalidates it and does not raise snp_shared. A Modified line also flushes its word in that cycle.
- R9: snp_shared is raised only for a snooped read whose tag matches a valid line at the snooped index.
- R10: A miss whose victim is Modified first issues a writeback (command code 2) carrying the victim's address and word, then the miss request. An Exclusive or Shared victim is dropped with no writeback.
- R11: While snp_valid is high, the block raises no bus request and completes no processor access.
- R12: A read miss completes in its grant cycle, with cpu_rdata equal to bus_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access pending, held until cpu_done |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address; low IDX_W bits select the line |
| cpu_wdata | input | DATA_W | Write word |
| cpu_done | output | 1 | Access completes this cycle |
| cpu_rdata | output | DATA_W | Read word, valid with cpu_done |
| bus_req_valid | output | 1 | Bus transaction requested |
| bus_req_cmd | output | 2 | 0 read, 1 read-for-ownership, 2 writeback |
| bus_req_addr | output | ADDR_W | Address of the transaction |
| bus_req_data | output | DATA_W | Writeback word |
| bus_gnt | input | 1 | Requested transaction completes this cycle |
| bus_shared_in | input | 1 | Wired-OR shared line, sampled with bus_gnt |
| bus_rdata | input | DATA_W | Fill word, valid with bus_gnt |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_rdx | input | 1 | 1 = snooped read-for-ownership, 0 = snooped read |
| snp_addr | input | ADDR_W | Snooped address |
| snp_shared | output | 1 | This cache holds the snooped line |
| snp_flush | output | 1 | This cache supplies dirty data |
| snp_data | output | DATA_W | Flushed word |

## Verification
On every cycle, the assertions check the following. A snoop silences the processor side. Flush and shared appear only with a matching kind of snoop. A line that has just flushed, or has just been invalidated, cannot answer a repeated snoop as dirty or shared. Writebacks never complete a processor access, and read fills return the bus word. The state a line actually holds is visible only through later traffic. So the silent Exclusive-to-Modified upgrade, the Shared-versus-Exclusive fill choice, the ignored fill word on an upgrade and the victim writeback address are shown by the bench's directed scenarios, which chain accesses and snoops.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
   typedef enum logic [1:0] {
      ST_I = 2'd0,
      ST_S = 2'd1,
      ST_E = 2'd2,
      ST_M = 2'd3
   } line_st_e;

   typedef enum logic [1:0] {
      BC_RD  = 2'd0,
      BC_RDX = 2'd1,
      BC_WB  = 2'd2
   } bus_cmd_e;
endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
   import mesi_pkg::*;
#(
   parameter int IDX_W  = 2,
   parameter int TAG_W  = 6,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  ra_idx,
   output line_st_e          ra_st,
   output logic [TAG_W-1:0]  ra_tag,
   output logic [DATA_W-1:0] ra_data,
   input  logic [IDX_W-1:0]  rb_idx,
   output line_st_e          rb_st,
   output logic [TAG_W-1:0]  rb_tag,
   output logic [DATA_W-1:0] rb_data,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  line_st_e          wr_st,
   input  logic              wr_fill,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [DATA_W-1:0] wr_data
);
   localparam int LINES = 1 << IDX_W;

   line_st_e          st_arr   [LINES];
   logic [TAG_W-1:0]  tag_arr  [LINES];
   logic [DATA_W-1:0] data_arr [LINES];

   for (genvar g = 0; g < LINES; g++) begin : g_line
      line_st_e          st_q;
      logic [TAG_W-1:0]  tag_q;
      logic [DATA_W-1:0] data_q;
      logic              sel;

      assign sel = wr_en && (wr_idx == IDX_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_q   <= ST_I;
            tag_q  <= '0;
            data_q <= '0;
         end else if (sel) begin
            st_q <= wr_st;
            if (wr_fill) begin
               tag_q  <= wr_tag;
               data_q <= wr_data;
            end
         end
      end

      assign st_arr[g]   = st_q;
      assign tag_arr[g]  = tag_q;
      assign data_arr[g] = data_q;
   end

   assign ra_st   = st_arr[ra_idx];
   assign ra_tag  = tag_arr[ra_idx];
   assign ra_data = data_arr[ra_idx];
   assign rb_st   = st_arr[rb_idx];
   assign rb_tag  = tag_arr[rb_idx];
   assign rb_data = data_arr[rb_idx];
endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
   import mesi_pkg::*;
#(
   parameter int TAG_W = 6
) (
   input  logic             snp_valid,
   input  logic             snp_rdx,
   input  logic [TAG_W-1:0] snp_tag,
   input  line_st_e         line_st,
   input  logic [TAG_W-1:0] line_tag,
   output logic             hold_hit,
   output logic             shared_o,
   output logic             flush_o,
   output line_st_e         next_st
);
   assign hold_hit = snp_valid && (line_st != ST_I) && (line_tag == snp_tag);
   assign shared_o = hold_hit && !snp_rdx;
   assign flush_o  = hold_hit && (line_st == ST_M);

   always_comb begin
      if (snp_rdx) next_st = ST_I;
      else         next_st = ST_S;
   end
endmodule

// File: rtl/mesi_cpu_unit.sv
module mesi_cpu_unit
   import mesi_pkg::*;
#(
   parameter int TAG_W = 6
) (
   input  logic             cpu_req,
   input  logic             cpu_wr,
   input  logic [TAG_W-1:0] cpu_tag,
   input  line_st_e         line_st,
   input  logic [TAG_W-1:0] line_tag,
   input  logic             snp_busy,
   input  logic             bus_gnt,
   input  logic             bus_shared_in,
   output logic             req_valid,
   output bus_cmd_e         req_cmd,
   output logic             req_victim,
   output logic             done,
   output logic             upd,
   output line_st_e         next_st,
   output logic             fill,
   output logic             from_bus
);
   logic active, tag_hit;

   assign active  = cpu_req && !snp_busy;
   assign tag_hit = (line_st != ST_I) && (line_tag == cpu_tag);

   always_comb begin
      req_valid  = 1'b0;
      req_cmd    = BC_RD;
      req_victim = 1'b0;
      done       = 1'b0;
      upd        = 1'b0;
      next_st    = line_st;
      fill       = 1'b0;
      from_bus   = 1'b0;
      if (active) begin
         if (tag_hit && (!cpu_wr || line_st == ST_M || line_st == ST_E)) begin
            done = 1'b1;
            if (cpu_wr) begin
               upd     = 1'b1;
               next_st = ST_M;
               fill    = 1'b1;
            end
         end else if (!tag_hit && line_st == ST_M) begin
            req_valid  = 1'b1;
            req_cmd    = BC_WB;
            req_victim = 1'b1;
            upd        = bus_gnt;
            next_st    = ST_I;
         end else begin
            req_valid = 1'b1;
            req_cmd   = cpu_wr ? BC_RDX : BC_RD;
            done      = bus_gnt;
            upd       = bus_gnt;
            fill      = 1'b1;
            from_bus  = !cpu_wr;
            if (cpu_wr)             next_st = ST_M;
            else if (bus_shared_in) next_st = ST_S;
            else                    next_st = ST_E;
         end
      end
   end
endmodule

// File: rtl/mesi_line_ctl.sv
module mesi_line_ctl
   import mesi_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int IDX_W  = 2,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_wr,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_done,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              bus_req_valid,
   output logic [1:0]        bus_req_cmd,
   output logic [ADDR_W-1:0] bus_req_addr,
   output logic [DATA_W-1:0] bus_req_data,
   input  logic              bus_gnt,
   input  logic              bus_shared_in,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              snp_valid,
   input  logic              snp_rdx,
   input  logic [ADDR_W-1:0] snp_addr,
   output logic              snp_shared,
   output logic              snp_flush,
   output logic [DATA_W-1:0] snp_data
);
   localparam int TAG_W = ADDR_W - IDX_W;

   if (IDX_W < 1 || IDX_W > 10) begin : g_bad_idx
      $error("mesi_line_ctl: IDX_W out of range");
   end
   if (ADDR_W <= IDX_W) begin : g_bad_addr
      $error("mesi_line_ctl: ADDR_W must exceed IDX_W");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("mesi_line_ctl: DATA_W must be positive");
   end

   logic [IDX_W-1:0]  c_idx, s_idx;
   logic [TAG_W-1:0]  c_tag, s_tag;
   line_st_e          c_st, s_st;
   logic [TAG_W-1:0]  c_ltag, s_ltag;
   logic [DATA_W-1:0] c_data, s_data;

   assign c_idx = cpu_addr[IDX_W-1:0];
   assign c_tag = cpu_addr[ADDR_W-1:IDX_W];
   assign s_idx = snp_addr[IDX_W-1:0];
   assign s_tag = snp_addr[ADDR_W-1:IDX_W];

   logic     s_hit, s_sh, s_fl;
   line_st_e s_next;

   mesi_snoop_unit #(.TAG_W(TAG_W)) i_snoop (
      .snp_valid(snp_valid), .snp_rdx(snp_rdx), .snp_tag(s_tag),
      .line_st(s_st), .line_tag(s_ltag),
      .hold_hit(s_hit), .shared_o(s_sh), .flush_o(s_fl), .next_st(s_next)
   );

   logic     c_rv, c_vic, c_done, c_upd, c_fill, c_bus;
   bus_cmd_e c_cmd;
   line_st_e c_next;

   mesi_cpu_unit #(.TAG_W(TAG_W)) i_cpu (
      .cpu_req(cpu_req), .cpu_wr(cpu_wr), .cpu_tag(c_tag),
      .line_st(c_st), .line_tag(c_ltag), .snp_busy(snp_valid),
      .bus_gnt(bus_gnt), .bus_shared_in(bus_shared_in),
      .req_valid(c_rv), .req_cmd(c_cmd), .req_victim(c_vic),
      .done(c_done), .upd(c_upd), .next_st(c_next),
      .fill(c_fill), .from_bus(c_bus)
   );

   logic              w_en, w_fill;
   logic [IDX_W-1:0]  w_idx;
   line_st_e          w_st;
   logic [DATA_W-1:0] w_data;

   always_comb begin
      if (s_hit) begin
         w_en   = 1'b1;
         w_idx  = s_idx;
         w_st   = s_next;
         w_fill = 1'b0;
      end else begin
         w_en   = c_upd;
         w_idx  = c_idx;
         w_st   = c_next;
         w_fill = c_fill;
      end
      w_data = c_bus ? bus_rdata : cpu_wdata;
   end

   mesi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) i_store (
      .clk(clk), .rst_n(rst_n),
      .ra_idx(c_idx), .ra_st(c_st), .ra_tag(c_ltag), .ra_data(c_data),
      .rb_idx(s_idx), .rb_st(s_st), .rb_tag(s_ltag), .rb_data(s_data),
      .wr_en(w_en), .wr_idx(w_idx), .wr_st(w_st), .wr_fill(w_fill),
      .wr_tag(c_tag), .wr_data(w_data)
   );

   assign cpu_done      = c_done;
   assign cpu_rdata     = c_bus ? bus_rdata : c_data;
   assign bus_req_valid = c_rv;
   assign bus_req_cmd   = c_cmd;
   assign bus_req_addr  = c_vic ? {c_ltag, c_idx} : cpu_addr;
   assign bus_req_data  = c_data;
   assign snp_shared    = s_sh;
   assign snp_flush     = s_fl;
   assign snp_data      = s_data;
endmodule

// File: rtl/mesi_ctl_chk.sv
module mesi_ctl_chk #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_done,
   input logic [DATA_W-1:0] cpu_rdata,
   input logic              bus_req_valid,
   input logic [1:0]        bus_req_cmd,
   input logic              bus_gnt,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              snp_valid,
   input logic              snp_rdx,
   input logic [ADDR_W-1:0] snp_addr,
   input logic              snp_shared,
   input logic              snp_flush
);
   logic past_ok;
   always_ff @(posedge clk) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   // R11
   snoop_quiets_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snp_valid |-> (!bus_req_valid && !cpu_done));

   // R6
   flush_needs_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snp_flush |-> snp_valid);

   // R9
   shared_only_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snp_shared |-> (snp_valid && !snp_rdx));

   // R12
   fill_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_gnt && bus_req_valid && bus_req_cmd == 2'd0) |-> (cpu_done && cpu_rdata == bus_rdata));

   // R10
   wb_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_gnt && bus_req_valid && bus_req_cmd == 2'd2) |-> !cpu_done);

   // R5
   silent_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_done && !bus_gnt) |-> !bus_req_valid);

   // R6
   no_second_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && snp_valid && $past(snp_valid && snp_flush) && snp_addr == $past(snp_addr))
      |-> !snp_flush);

   // R8
   no_shared_after_rdx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && snp_valid && !snp_rdx && $past(snp_valid && snp_rdx)
       && snp_addr == $past(snp_addr)) |-> !snp_shared);
endmodule

bind mesi_line_ctl mesi_ctl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
   .bus_req_valid(bus_req_valid), .bus_req_cmd(bus_req_cmd), .bus_gnt(bus_gnt),
   .bus_rdata(bus_rdata), .snp_valid(snp_valid), .snp_rdx(snp_rdx),
   .snp_addr(snp_addr), .snp_shared(snp_shared), .snp_flush(snp_flush)
);

// File: tb/test_mesi_line_ctl.sv
module test_mesi_line_ctl;
   localparam int CLK_P  = 10;
   localparam int ADDR_W = 8;
   localparam int DATA_W = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cpu_req = 1'b0, cpu_wr = 1'b0;
   logic [ADDR_W-1:0] cpu_addr = '0;
   logic [DATA_W-1:0] cpu_wdata = '0;
   logic              cpu_done;
   logic [DATA_W-1:0] cpu_rdata;
   logic              bus_req_valid;
   logic [1:0]        bus_req_cmd;
   logic [ADDR_W-1:0] bus_req_addr;
   logic [DATA_W-1:0] bus_req_data;
   logic              bus_gnt = 1'b0, bus_shared_in = 1'b0;
   logic [DATA_W-1:0] bus_rdata = '0;
   logic              snp_valid = 1'b0, snp_rdx = 1'b0;
   logic [ADDR_W-1:0] snp_addr = '0;
   logic              snp_shared, snp_flush;
   logic [DATA_W-1:0] snp_data;

   int n_run = 0, n_fail = 0;

   always #(CLK_P/2) clk = ~clk;

   mesi_line_ctl #(.ADDR_W(ADDR_W), .IDX_W(2), .DATA_W(DATA_W)) i_mesi_line_ctl (.*);

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Runs one processor access, granting each bus request at once.
   int               ncmd;
   logic [1:0]       cmd0, cmd1;
   logic [ADDR_W-1:0] adr0;
   logic [DATA_W-1:0] dat0, rdv;

   task automatic cpu_op(input bit wr, input logic [ADDR_W-1:0] a,
                         input logic [DATA_W-1:0] wd, input bit sh,
                         input logic [DATA_W-1:0] md);
      bit fin = 0;
      ncmd = 0; cmd0 = 2'd3; cmd1 = 2'd3; adr0 = '0; dat0 = '0; rdv = '0;
      @(negedge clk);
      cpu_req = 1'b1; cpu_wr = wr; cpu_addr = a; cpu_wdata = wd;
      for (int k = 0; k < 6 && !fin; k++) begin
         #1;
         if (bus_req_valid) begin
            if (ncmd == 0) begin cmd0 = bus_req_cmd; adr0 = bus_req_addr; dat0 = bus_req_data; end
            else cmd1 = bus_req_cmd;
            ncmd++;
            bus_gnt = 1'b1; bus_shared_in = sh; bus_rdata = md;
         end
         #1;
         if (cpu_done) begin fin = 1; rdv = cpu_rdata; end
         @(negedge clk);
         bus_gnt = 1'b0; bus_shared_in = 1'b0;
      end
      cpu_req = 1'b0; cpu_wr = 1'b0;
      chk(fin, "access completes", int'(fin), 1);
   endtask

   logic              s_sh, s_fl;
   logic [DATA_W-1:0] s_dat;
   task automatic snoop(input bit rdx, input logic [ADDR_W-1:0] a);
      @(negedge clk);
      snp_valid = 1'b1; snp_rdx = rdx; snp_addr = a;
      #1;
      s_sh = snp_shared; s_fl = snp_flush; s_dat = snp_data;
      @(negedge clk);
      snp_valid = 1'b0; snp_rdx = 1'b0;
   endtask

   task automatic t_reset;
      snoop(1'b0, 8'h10);
      chk(!s_sh && !s_fl, "R1 snoop after reset", {s_sh, s_fl}, 0);
      chk(!s_sh, "R9 no shared on invalid", s_sh, 0);
      cpu_op(1'b0, 8'h10, '0, 1'b0, 16'hAAAA);
      chk(ncmd == 1 && cmd0 == 2'd0, "R1 first read issues bus read", ncmd, 1);
      chk(rdv == 16'hAAAA, "R12 fill word returned", rdv, 16'hAAAA);
   endtask

   task automatic t_exclusive_path;
      cpu_op(1'b0, 8'h10, '0, 1'b0, 16'h0);
      chk(ncmd == 0 && rdv == 16'hAAAA, "R5 read hit Exclusive", rdv, 16'hAAAA);
      cpu_op(1'b1, 8'h10, 16'h1234, 1'b0, 16'h0);
      chk(ncmd == 0, "R3 silent write on Exclusive", ncmd, 0);
      snoop(1'b0, 8'h10);
      chk(s_sh && s_fl, "R6 flush and shared on Modified", {s_sh, s_fl}, 3);
      chk(s_dat == 16'h1234, "R6 flushed word", s_dat, 16'h1234);
      cpu_op(1'b1, 8'h10, 16'h5555, 1'b0, 16'hDEAD);
      chk(ncmd == 1 && cmd0 == 2'd1, "R4 upgrade from Shared uses read-for-ownership", cmd0, 1);
      snoop(1'b1, 8'h10);
      chk(s_fl && s_dat == 16'h5555, "R4 upgrade keeps written word", s_dat, 16'h5555);
      chk(!s_sh, "R8 no shared on read-for-ownership", s_sh, 0);
      snoop(1'b0, 8'h10);
      chk(!s_sh && !s_fl, "R8 line invalid after read-for-ownership", {s_sh, s_fl}, 0);
   endtask

   task automatic t_shared_fill;
      cpu_op(1'b0, 8'h21, '0, 1'b1, 16'h0BB0);
      chk(ncmd == 1 && cmd0 == 2'd0, "R2 read miss bus read", cmd0, 0);
      snoop(1'b0, 8'h21);
      chk(s_sh && !s_fl, "R7 Shared answers shared without flush", {s_sh, s_fl}, 2);
      cpu_op(1'b1, 8'h21, 16'h0C0C, 1'b0, 16'h0);
      chk(ncmd == 1 && cmd0 == 2'd1, "R2 fill with shared_in gives Shared", ncmd, 1);
   endtask

   task automatic t_exclusive_snooped;
      cpu_op(1'b0, 8'h22, '0, 1'b0, 16'h2222);
      snoop(1'b0, 8'h22);
      chk(s_sh && !s_fl, "R7 Exclusive answers shared without flush", {s_sh, s_fl}, 2);
      cpu_op(1'b1, 8'h22, 16'h2223, 1'b0, 16'h0);
      chk(ncmd == 1 && cmd0 == 2'd1, "R7 Exclusive moved to Shared", ncmd, 1);
   endtask

   task automatic t_evict;
      cpu_op(1'b1, 8'h23, 16'h7777, 1'b0, 16'h0);
      chk(ncmd == 1 && cmd0 == 2'd1, "R4 write miss read-for-ownership", cmd0, 1);
      cpu_op(1'b0, 8'h43, '0, 1'b0, 16'h4444);
      chk(ncmd == 2 && cmd0 == 2'd2 && cmd1 == 2'd0, "R10 writeback then read", ncmd, 2);
      chk(adr0 == 8'h23, "R10 writeback address", adr0, 8'h23);
      chk(dat0 == 16'h7777, "R10 writeback word", dat0, 16'h7777);
      chk(rdv == 16'h4444, "R12 fill after writeback", rdv, 16'h4444);
      cpu_op(1'b0, 8'h83, '0, 1'b0, 16'h8383);
      chk(ncmd == 1 && cmd0 == 2'd0, "R10 clean victim dropped silently", ncmd, 1);
   endtask

   task automatic t_snoop_tags;
      snoop(1'b0, 8'h03);
      chk(!s_sh, "R9 tag mismatch gives no shared", s_sh, 0);
      snoop(1'b1, 8'h83);
      chk(!s_sh && !s_fl, "R8 Exclusive invalidated without flush", {s_sh, s_fl}, 0);
      cpu_op(1'b0, 8'h83, '0, 1'b0, 16'h0);
      chk(ncmd == 1, "R8 read misses after invalidation", ncmd, 1);
   endtask

   task automatic t_priority;
      @(negedge clk);
      cpu_req = 1'b1; cpu_wr = 1'b0; cpu_addr = 8'h30;
      snp_valid = 1'b1; snp_rdx = 1'b0; snp_addr = 8'h83;
      #1;
      chk(!bus_req_valid && !cpu_done, "R11 snoop blocks processor side", {bus_req_valid, cpu_done}, 0);
      @(negedge clk);
      snp_valid = 1'b0; cpu_req = 1'b0;
      cpu_op(1'b0, 8'h30, '0, 1'b0, 16'h3030);
      chk(ncmd == 1 && rdv == 16'h3030, "R11 access proceeds after snoop", rdv, 16'h3030);
      cpu_op(1'b1, 8'h30, 16'h9999, 1'b0, 16'h0);
      chk(ncmd == 0, "R3 silent upgrade again", ncmd, 0);
      cpu_op(1'b1, 8'h30, 16'hABCD, 1'b0, 16'h0);
      chk(ncmd == 0, "R5 write hit Modified", ncmd, 0);
      cpu_op(1'b0, 8'h30, '0, 1'b0, 16'h0);
      chk(ncmd == 0 && rdv == 16'hABCD, "R5 read hit Modified", rdv, 16'hABCD);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      #1;
      chk(!bus_req_valid && !cpu_done && !snp_shared && !snp_flush, "R1 idle outputs after reset",
          {bus_req_valid, cpu_done, snp_shared, snp_flush}, 0);
      t_reset();
      t_exclusive_path();
      t_shared_fill();
      t_exclusive_snooped();
      t_evict();
      t_snoop_tags();
      t_priority();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule